// File: doc/BRIEF.md
# Iterative Floating-Point Square Root

This block takes one unpacked floating-point operand and returns its square root in the same unpacked form. The operand arrives as a class code, a sign, a signed unbiased exponent and a fixed-point fraction whose hidden bit sits at bit `HIDDEN`. The fraction is expected to be normalised, meaning its hidden bit is set. A one-cycle `start` pulse launches the operation.

Zero, infinity, NaN and negative operands need no arithmetic. For these the block decides the result on the start edge and raises `done` on that same edge. A positive normalised number goes through a restoring shift-subtract recurrence, one result bit per clock. The bit weight starts at the hidden-bit position and halves each cycle, so the block takes `HIDDEN+1` steps. Any remainder left over at the end is folded into the result LSB as a sticky bit. Final rounding to a packed format belongs to a later stage.

Top module: `fsqrt_iter`

## Requirements
- R1: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN. A zero operand of either sign returns class 0 with the same sign, exponent 0 and fraction 0, with both flags low.
- R2: For a special operand (any class except a positive number), `done` pulses on the start edge itself. For a positive number, `busy` stays high for `HIDDEN+1` cycles and `done` pulses on the `HIDDEN+1`-th clock edge after the start edge.
- R3: The result exponent of a number is the operand exponent arithmetically shifted right by one bit, so -3 gives -2 and 5 gives 2.
- R4: Let Y be the operand fraction, doubled when the exponent is odd. The result fraction with its LSB cleared of sticky (q) satisfies q² ≤ Y·2^HIDDEN < (q+1)². Bit `HIDDEN` of the result is set, and the result class is 1 with sign 0.
- R5: If the final remainder is nonzero, the result fraction LSB is forced to 1 and `inexact` is raised. An exact root leaves `inexact` low.
- R6: +infinity returns +infinity (class 2, sign 0) with no flags.
- R7: A negative number, negative infinity, or a class code of 5 to 7 returns a quiet NaN with sign 0, exponent 0 and fraction 0, and raises `invalid`.
- R8: A signalling NaN returns a quiet NaN that keeps the operand sign and fraction, and raises `invalid`. A quiet NaN is passed through with no flag.
- R9: `start` is ignored while `busy` is high. The running operation's result and timing are unchanged, and no extra `done` appears.
- R10: After reset, `busy`, `done`, `inexact` and `invalid` are low. Result outputs change only on an edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled while idle |
| op_cls | input | 3 | Operand class code |
| op_sign | input | 1 | Operand sign |
| op_exp | input | EXP_W | Operand unbiased exponent, signed |
| op_frac | input | FRAC_W | Operand fraction, hidden bit at HIDDEN |
| busy | output | 1 | Recurrence in progress |
| done | output | 1 | One-cycle result strobe |
| res_cls | output | 3 | Result class code |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent, signed |
| res_frac | output | FRAC_W | Result fraction with sticky LSB |
| inexact | output | 1 | Root was not exact |
| invalid | output | 1 | Invalid operation |

## Verification
The bench uses the default widths: a 32-bit fraction with the hidden bit at 30 and a 12-bit exponent. With these, Y·2^30 fits in 62 bits, so the bench can find the exact integer root with a 64-bit binary search. The search reaches both odd and even exponents, negative exponents where the arithmetic shift rounds toward minus infinity, and the largest doubled radicand. The 31-step latency is short enough that a start pulse can be placed in the middle of a run, to show that it is ignored.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fclass_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/fsqrt_special.sv
module fsqrt_special
    import fsqrt_pkg::*;
#(
    parameter int FRAC_W = 32
) (
    input  logic [2:0]        cls_i,
    input  logic              sign_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              is_special_o,
    output logic [2:0]        cls_o,
    output logic              sign_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              invalid_o
);
    always_comb begin
        is_special_o = 1'b1;
        cls_o        = CLS_QNAN;
        sign_o       = 1'b0;
        frac_o       = '0;
        invalid_o    = 1'b1;
        case (cls_i)
            CLS_ZERO: begin
                cls_o     = CLS_ZERO;
                sign_o    = sign_i;
                invalid_o = 1'b0;
            end
            CLS_NUM: begin
                // positive numbers go to the recurrence
                is_special_o = sign_i;
            end
            CLS_INF: begin
                if (!sign_i) begin
                    cls_o     = CLS_INF;
                    invalid_o = 1'b0;
                end
            end
            CLS_QNAN: begin
                sign_o    = sign_i;
                frac_o    = frac_i;
                invalid_o = 1'b0;
            end
            CLS_SNAN: begin
                sign_o = sign_i;
                frac_o = frac_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fsqrt_step.sv
module fsqrt_step #(
    parameter int FRAC_W = 32,
    parameter int W      = FRAC_W + 2
) (
    input  logic [W-1:0]      rem_i,
    input  logic [W-1:0]      acc_i,
    input  logic [FRAC_W-1:0] root_i,
    input  logic [FRAC_W-1:0] bit_i,
    output logic [W-1:0]      rem_o,
    output logic [W-1:0]      acc_o,
    output logic [FRAC_W-1:0] root_o,
    output logic [FRAC_W-1:0] bit_o
);
    logic [W-1:0] bit_w;
    logic [W-1:0] trial;
    logic [W-1:0] rem_sub;

    always_comb begin
        bit_w   = W'(bit_i);
        trial   = acc_i + bit_w;
        rem_sub = rem_i;
        acc_o   = acc_i;
        root_o  = root_i;
        if (trial <= rem_i) begin
            acc_o   = trial + bit_w;
            rem_sub = rem_i - trial;
            root_o  = root_i | bit_i;
        end
        rem_o = {rem_sub[W-2:0], 1'b0};
        bit_o = bit_i >> 1;
    end
endmodule

// File: rtl/fsqrt_iter.sv
module fsqrt_iter
    import fsqrt_pkg::*;
#(
    parameter int FRAC_W = 32,
    parameter int HIDDEN = 30,
    parameter int EXP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2:0]              op_cls,
    input  logic                    op_sign,
    input  logic signed [EXP_W-1:0] op_exp,
    input  logic [FRAC_W-1:0]       op_frac,
    output logic                    busy,
    output logic                    done,
    output logic [2:0]              res_cls,
    output logic                    res_sign,
    output logic signed [EXP_W-1:0] res_exp,
    output logic [FRAC_W-1:0]       res_frac,
    output logic                    inexact,
    output logic                    invalid
);
    localparam int W = FRAC_W + 2;
    localparam logic [FRAC_W-1:0] BIT_INIT = FRAC_W'(1) << HIDDEN;

    typedef struct packed {
        phase_e             ph;
        logic [W-1:0]       rem;
        logic [W-1:0]       acc;
        logic [FRAC_W-1:0]  root;
        logic [FRAC_W-1:0]  wbit;
        logic [EXP_W-1:0]   wexp;
        logic [2:0]         rcls;
        logic               rsign;
        logic [EXP_W-1:0]   rexp;
        logic [FRAC_W-1:0]  rfrac;
        logic               rdone;
        logic               rinexact;
        logic               rinvalid;
    } regs_t;

    regs_t r_q, r_d;

    logic              sp_is;
    logic [2:0]        sp_cls;
    logic              sp_sign;
    logic [FRAC_W-1:0] sp_frac;
    logic              sp_inv;

    fsqrt_special #(.FRAC_W(FRAC_W)) u_special (
        .cls_i        (op_cls),
        .sign_i       (op_sign),
        .frac_i       (op_frac),
        .is_special_o (sp_is),
        .cls_o        (sp_cls),
        .sign_o       (sp_sign),
        .frac_o       (sp_frac),
        .invalid_o    (sp_inv)
    );

    logic [W-1:0]      rem_n;
    logic [W-1:0]      acc_n;
    logic [FRAC_W-1:0] root_n;
    logic [FRAC_W-1:0] bit_n;

    fsqrt_step #(.FRAC_W(FRAC_W), .W(W)) u_step (
        .rem_i  (r_q.rem),
        .acc_i  (r_q.acc),
        .root_i (r_q.root),
        .bit_i  (r_q.wbit),
        .rem_o  (rem_n),
        .acc_o  (acc_n),
        .root_o (root_n),
        .bit_o  (bit_n)
    );

    logic sticky;
    assign sticky = (rem_n != '0);

    always_comb begin
        r_d       = r_q;
        r_d.rdone = 1'b0;
        case (r_q.ph)
            ST_IDLE: begin
                if (start) begin
                    if (sp_is) begin
                        r_d.rcls     = sp_cls;
                        r_d.rsign    = sp_sign;
                        r_d.rexp     = '0;
                        r_d.rfrac    = sp_frac;
                        r_d.rinexact = 1'b0;
                        r_d.rinvalid = sp_inv;
                        r_d.rdone    = 1'b1;
                    end else begin
                        r_d.rem  = op_exp[0] ? {1'b0, op_frac, 1'b0}
                                             : {2'b00, op_frac};
                        r_d.acc  = '0;
                        r_d.root = '0;
                        r_d.wbit = BIT_INIT;
                        r_d.wexp = op_exp >>> 1;
                        r_d.ph   = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                r_d.rem  = rem_n;
                r_d.acc  = acc_n;
                r_d.root = root_n;
                r_d.wbit = bit_n;
                if (bit_n == '0) begin
                    r_d.ph       = ST_IDLE;
                    r_d.rcls     = CLS_NUM;
                    r_d.rsign    = 1'b0;
                    r_d.rexp     = r_q.wexp;
                    r_d.rfrac    = root_n | {{(FRAC_W-1){1'b0}}, sticky};
                    r_d.rinexact = sticky;
                    r_d.rinvalid = 1'b0;
                    r_d.rdone    = 1'b1;
                end
            end
            default: r_d.ph = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ph   <= ST_IDLE;
            r_q.rcls <= CLS_ZERO;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.ph == ST_RUN);
    assign done     = r_q.rdone;
    assign res_cls  = r_q.rcls;
    assign res_sign = r_q.rsign;
    assign res_exp  = r_q.rexp;
    assign res_frac = r_q.rfrac;
    assign inexact  = r_q.rinexact;
    assign invalid  = r_q.rinvalid;

    // R2: the result strobe never overlaps a running recurrence
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: the bit weight is a single bit or empty
    a_r2_bit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_q.wbit));

    // R4: a numeric result is normalised at the hidden position
    a_r4_hidden_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_cls == CLS_NUM) |-> (res_frac[HIDDEN] && (res_frac >> (HIDDEN+1)) == '0));

    // R5: inexact only on numbers, always with the sticky LSB set
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inexact) |-> (res_cls == CLS_NUM && res_frac[0]));

    // R7/R8: invalid always comes with a quiet NaN
    a_r7_invalid_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> (res_cls == CLS_QNAN));

    // R9/R10: results hold while the recurrence runs
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(res_frac) && $stable(res_exp) && $stable(res_cls)));
endmodule

// File: tb/fsqrt_iter_test.sv
`timescale 1ns/1ps
module fsqrt_iter_test;
    localparam int FRAC_W = 32;
    localparam int HIDDEN = 30;
    localparam int EXP_W  = 12;
    localparam int LAT_NUM = HIDDEN + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op_cls = 3'd0;
    logic op_sign = 1'b0;
    logic signed [EXP_W-1:0] op_exp = '0;
    logic [FRAC_W-1:0] op_frac = '0;
    logic busy, done, res_sign, inexact, invalid;
    logic [2:0] res_cls;
    logic signed [EXP_W-1:0] res_exp;
    logic [FRAC_W-1:0] res_frac;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fsqrt_iter #(.FRAC_W(FRAC_W), .HIDDEN(HIDDEN), .EXP_W(EXP_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_cls(op_cls),
        .op_sign(op_sign), .op_exp(op_exp), .op_frac(op_frac),
        .busy(busy), .done(done), .res_cls(res_cls), .res_sign(res_sign),
        .res_exp(res_exp), .res_frac(res_frac), .inexact(inexact),
        .invalid(invalid)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic longint unsigned ref_root(input longint unsigned n);
        longint unsigned lo = 0;
        longint unsigned hi = 64'd1 << 32;
        while (hi - lo > 1) begin
            longint unsigned mid = (lo + hi) >> 1;
            if (mid * mid <= n) lo = mid;
            else hi = mid;
        end
        return lo;
    endfunction

    function automatic int floor_half(input int e);
        if (e >= 0) return e / 2;
        return -((1 - e) / 2);
    endfunction

    int lat;

    task automatic launch(input logic [2:0] c, input logic s, input int e, input logic [FRAC_W-1:0] f);
        op_cls = c; op_sign = s; op_exp = EXP_W'(e); op_frac = f;
        start = 1'b1;
        lat = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (done) break;
        end
    endtask

    task automatic run_num(input int e, input logic [FRAC_W-1:0] f, input string tag);
        longint unsigned y, n, q;
        bit rem_nz;
        launch(3'd1, 1'b0, e, f);
        y = (e % 2 != 0) ? (longint'(f) << 1) : longint'(f);
        n = y << HIDDEN;
        q = ref_root(n);
        rem_nz = (q * q != n);
        check(lat == LAT_NUM, {tag, " R2 latency"}, lat, LAT_NUM);
        check(res_cls == 3'd1 && res_sign == 1'b0, {tag, " R4 class"}, res_cls, 1);
        check(res_exp == EXP_W'(floor_half(e)), {tag, " R3 exponent"}, res_exp, floor_half(e));
        check(res_frac == FRAC_W'(q | longint'(rem_nz)), {tag, " R4 R5 fraction"}, res_frac, q | longint'(rem_nz));
        check(inexact == rem_nz && !invalid, {tag, " R5 inexact"}, inexact, rem_nz);
    endtask

    task automatic run_spec(input logic [2:0] c, input logic s, input logic [FRAC_W-1:0] f,
                            input logic [2:0] ec, input logic es, input logic [FRAC_W-1:0] ef,
                            input logic einv, input string tag);
        launch(c, s, 7, f);
        check(lat == 1, {tag, " R2 special latency"}, lat, 1);
        check(res_cls == ec && res_sign == es, {tag, " class/sign"}, {res_cls, res_sign}, {ec, es});
        check(res_frac == ef && res_exp == 0, {tag, " frac/exp"}, res_frac, ef);
        check(invalid == einv && !inexact, {tag, " flags"}, invalid, einv);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        #1;
        check(!busy && !done && !inexact && !invalid, "R10 reset state", {busy, done, inexact, invalid}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        run_spec(3'd0, 1'b0, 32'h0, 3'd0, 1'b0, 32'h0, 1'b0, "R1 +0");
        run_spec(3'd0, 1'b1, 32'h0, 3'd0, 1'b1, 32'h0, 1'b0, "R1 -0");
        run_spec(3'd2, 1'b0, 32'h0, 3'd2, 1'b0, 32'h0, 1'b0, "R6 +inf");
        run_spec(3'd2, 1'b1, 32'h0, 3'd3, 1'b0, 32'h0, 1'b1, "R7 -inf");
        run_spec(3'd1, 1'b1, 32'h4000_0000, 3'd3, 1'b0, 32'h0, 1'b1, "R7 negative number");
        run_spec(3'd6, 1'b0, 32'h4000_0000, 3'd3, 1'b0, 32'h0, 1'b1, "R7 bad class");
        run_spec(3'd4, 1'b1, 32'h1234_5678, 3'd3, 1'b1, 32'h1234_5678, 1'b1, "R8 snan");
        run_spec(3'd3, 1'b1, 32'h2000_0001, 3'd3, 1'b1, 32'h2000_0001, 1'b0, "R8 qnan");

        run_num(0, 32'h4000_0000, "R4 one");
        run_num(2, 32'h4000_0000, "R3 four");
        run_num(1, 32'h4000_0000, "R5 two");
        run_num(-1, 32'h4000_0000, "R3 half");
        run_num(-3, 32'h6400_0000, "R3 neg odd");
        run_num(0, 32'h6400_0000, "R5 exact 1.5625");
        run_num(5, 32'h7fff_ffff, "R4 max odd");
        run_num(-100, 32'h7fff_ffff, "R4 max even");

        // R9: a start pulse mid-run is ignored
        op_cls = 3'd1; op_sign = 1'b0; op_exp = 12'sd3; op_frac = 32'h5555_5555;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 5; k++) @(negedge clk);
            op_cls = 3'd0; op_exp = 0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 7; k < LAT_NUM; k++) begin
                if (done) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R9 no early done", seen, 0);
            check(done == 1'b1, "R9 done on time", done, 1);
            check(res_cls == 3'd1 && res_exp == 1, "R9 result kept", res_exp, 1);
            check(res_frac == FRAC_W'(ref_root((64'h5555_5555 << 1) << HIDDEN) | 1), "R9 fraction kept",
                  res_frac, ref_root((64'h5555_5555 << 1) << HIDDEN) | 1);
            @(negedge clk);
            check(!done, "R9 single strobe", done, 0);
        end

        for (int i = 0; i < 300; i++) begin
            logic [FRAC_W-1:0] f;
            int e;
            f = 32'h4000_0000 | ($urandom() & 32'h3fff_ffff);
            e = int'($urandom_range(400)) - 200;
            run_num(e, f, "R4 random");
            if ((i % 7) == 0) @(negedge clk);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule